// File: doc/BRIEF.md
# Control-Transfer History Ring

This block keeps a short, rolling history of the control transfers a core has taken: ordinary taken branches, interrupts and exceptions. Each transfer is kept as a pair, the address it came from and the address it went to, in a ring of `DEPTH` pairs. A pointer always names the pair that holds the newest transfer, so software reading the ring walks backwards from the pointer to rebuild recent control flow. Beside the ring sit two last-exception registers. They keep only the most recent interrupt or exception, so that transfer is not lost when ordinary branches later wrap the ring.

A capture port accepts at most one transfer per cycle. A flat register index space gives combinational read access to every ring entry, the pointer, a control register and the last-exception pair. Writes reach only the control register. That register holds a recording enable, a freeze-on-interrupt enable and a write-one release bit. A performance-monitor interrupt request can freeze the history so that the transfers leading up to a counter overflow can be examined.

Recording is run by a three-state machine:
- `ST_IDLE`: recording off.
- `ST_RECORD`: capture events are written.
- `ST_FROZEN`: contents held after an interrupt request.

It has these transitions:
- IDLE→RECORD when the enable is written to one.
- RECORD→IDLE when the enable is written to zero.
- RECORD→FROZEN on an interrupt request while the freeze enable is set. This transition wins over a control write in the same cycle.
- FROZEN→RECORD on a release write with the enable set.
- FROZEN→IDLE on a release write with the enable clear.

Top module: `xfer_history_ring`

## Requirements
- R1: After reset the pointer, every ring entry, both last-exception registers and the control register read zero, and the state is IDLE.
- R2: Each recorded event first advances the pointer by one modulo `DEPTH`, then writes the pair at the new pointer value. The pointer reads back, zero-extended, at index 0x1C9.
- R3: Source entry i reads at index 0x40+i and destination entry i reads at index 0x60+i, for i from 0 to `DEPTH`-1.
- R4: Every event kind recorded in RECORD state is written into the ring: kind 0 (branch), kind 1 (interrupt), kind 2 (exception) and kind 3 (reserved, treated as a branch).
- R5: Only kinds 1 and 2 load the last-exception pair, which reads at index 0x1DD (source) and index 0x1DE (destination). Kinds 0 and 3 leave that pair unchanged.
- R6: In IDLE state a capture event changes neither the pointer nor any entry. A control write that sets the enable takes effect from the following cycle.
- R7: The control register at index 0x1D9 is written with bit 0 = enable, bit 1 = freeze enable and bit 2 = release. Reading it returns bit 0 = enable, bit 1 = freeze enable and bit 3 = frozen, with all other bits zero. An interrupt request while the freeze enable is clear has no effect.
- R8: An interrupt request in RECORD state with the freeze enable set moves the state to FROZEN. While FROZEN, capture events are ignored and reads still return the held contents.
- R9: A write with the release bit set leaves FROZEN, going to RECORD if the written enable is one and to IDLE otherwise.
- R10: An event that arrives in the same cycle as the freezing interrupt request is still recorded.
- R11: A read from any index that is not mapped returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_valid | input | 1 | A transfer event is present this cycle |
| cap_kind | input | 2 | Event kind: 0 branch, 1 interrupt, 2 exception, 3 reserved |
| cap_from | input | AW | Source address of the transfer |
| cap_to | input | AW | Destination address of the transfer |
| pmi_req | input | 1 | Performance-monitor interrupt request |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IW | Register write index |
| wr_bits | input | 3 | Write data: release, freeze enable, enable |
| rd_idx | input | IW | Register read index |
| rd_data | output | AW | Combinational read data |

## Verification
The ring is filled with more events than it has pairs, and the event kinds are rotated through all four codes. This separates correct modulo wrap-around from overwriting the wrong slot, and it separates a last-exception update driven by kind from one driven by every event. Each step is followed by a sweep over every index from 0x000 to 0x1FF. The sweep catches decode aliasing, a source/destination swap and nonzero reads from unmapped space. Disabled, frozen, same-cycle-freeze and release-to-idle sequences are applied with events offered throughout, which tells an ignored event apart from a silently recorded one.

// File: rtl/xfer_hist_pkg.sv
package xfer_hist_pkg;

    typedef enum logic [1:0] {
        XK_BRANCH = 2'd0,
        XK_INTR   = 2'd1,
        XK_EXCP   = 2'd2,
        XK_RSVD   = 2'd3
    } xfer_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RECORD = 2'd1,
        ST_FROZEN = 2'd2
    } rec_state_e;

    localparam int unsigned CB_EN     = 0;
    localparam int unsigned CB_FRZ_EN = 1;
    localparam int unsigned CB_REL    = 2;
    localparam int unsigned CB_FROZEN = 3;

    function automatic logic kind_is_exc(input logic [1:0] k);
        return (k == XK_INTR) || (k == XK_EXCP);
    endfunction

endpackage

// File: rtl/xfer_ctrl_fsm.sv
module xfer_ctrl_fsm
    import xfer_hist_pkg::*;
#(
    parameter int unsigned IW = 12,
    parameter logic [IW-1:0] CTRL_IDX = 12'h1D9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_valid,
    input  logic          pmi_req,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [2:0]    wr_bits,
    output logic          rec_en,
    output logic          ctl_en,
    output logic          ctl_frz_en,
    output logic          frozen
);

    rec_state_e st_q, st_d;
    logic en_q, fen_q;
    logic ctrl_wr, en_d, fen_d, release_wr;

    always_comb begin
        ctrl_wr    = wr_en && (wr_idx == CTRL_IDX);
        en_d       = ctrl_wr ? wr_bits[CB_EN]     : en_q;
        fen_d      = ctrl_wr ? wr_bits[CB_FRZ_EN] : fen_q;
        release_wr = ctrl_wr && wr_bits[CB_REL];
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (en_d) st_d = ST_RECORD;
            end
            ST_RECORD: begin
                if (pmi_req && fen_q) st_d = ST_FROZEN;
                else if (!en_d)       st_d = ST_IDLE;
            end
            ST_FROZEN: begin
                if (release_wr) st_d = en_d ? ST_RECORD : ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            fen_q <= 1'b0;
        end else begin
            en_q  <= en_d;
            fen_q <= fen_d;
        end
    end

    // outputs
    always_comb begin
        rec_en     = (st_q == ST_RECORD) && cap_valid;
        frozen     = (st_q == ST_FROZEN);
        ctl_en     = en_q;
        ctl_frz_en = fen_q;
    end

    AST_FREEZE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RECORD && pmi_req && fen_q) |=> (st_q == ST_FROZEN)); // R8
    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FROZEN && !(wr_en && wr_idx == CTRL_IDX && wr_bits[CB_REL])) |=> (st_q == ST_FROZEN)); // R8
    AST_NO_FREEZE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_FROZEN && !fen_q) |=> (st_q != ST_FROZEN)); // R7
    AST_RELEASE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FROZEN && wr_en && wr_idx == CTRL_IDX && wr_bits[CB_REL]) |=> (st_q != ST_FROZEN)); // R9

endmodule

// File: rtl/xfer_ring_store.sv
module xfer_ring_store #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned AW    = 32,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rec_en,
    input  logic [AW-1:0]       cap_from,
    input  logic [AW-1:0]       cap_to,
    output logic [PW-1:0]       ptr_q,
    output logic [DEPTH*AW-1:0] src_flat,
    output logic [DEPTH*AW-1:0] dst_flat
);

    logic [PW-1:0] ptr_nxt;

    always_comb ptr_nxt = ptr_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ptr_q <= '0;
        else if (rec_en) ptr_q <= ptr_nxt;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_flat[g*AW +: AW] <= '0;
                dst_flat[g*AW +: AW] <= '0;
            end else if (rec_en && (ptr_nxt == PW'(g))) begin
                src_flat[g*AW +: AW] <= cap_from;
                dst_flat[g*AW +: AW] <= cap_to;
            end
        end
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rec_en |=> (ptr_q == PW'($past(ptr_q) + 1'b1))); // R2
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_en |=> $stable(ptr_q)); // R6
    AST_NEWEST_AT_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        rec_en |=> (src_flat[AW*int'(ptr_q) +: AW] == $past(cap_from)
                 && dst_flat[AW*int'(ptr_q) +: AW] == $past(cap_to))); // R2
    AST_RING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_en |=> ($stable(src_flat) && $stable(dst_flat))); // R8

endmodule

// File: rtl/xfer_exc_latch.sv
module xfer_exc_latch
    import xfer_hist_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rec_en,
    input  logic [1:0]    cap_kind,
    input  logic [AW-1:0] cap_from,
    input  logic [AW-1:0] cap_to,
    output logic [AW-1:0] lex_from_q,
    output logic [AW-1:0] lex_to_q
);

    logic load;

    always_comb load = rec_en && kind_is_exc(cap_kind);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lex_from_q <= '0;
            lex_to_q   <= '0;
        end else if (load) begin
            lex_from_q <= cap_from;
            lex_to_q   <= cap_to;
        end
    end

    AST_LEX_SKIP_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_kind == XK_BRANCH || cap_kind == XK_RSVD) |=> ($stable(lex_from_q) && $stable(lex_to_q))); // R5
    AST_LEX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_en && (cap_kind == XK_INTR || cap_kind == XK_EXCP)) |=> (lex_to_q == $past(cap_to))); // R5

endmodule

// File: rtl/xfer_read_mux.sv
module xfer_read_mux
    import xfer_hist_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned AW    = 32,
    parameter int unsigned IW    = 12,
    parameter logic [IW-1:0] SRC_BASE = 12'h040,
    parameter logic [IW-1:0] DST_BASE = 12'h060,
    parameter logic [IW-1:0] PTR_IDX  = 12'h1C9,
    parameter logic [IW-1:0] CTRL_IDX = 12'h1D9,
    parameter logic [IW-1:0] LEXF_IDX = 12'h1DD,
    parameter logic [IW-1:0] LEXT_IDX = 12'h1DE,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [IW-1:0]       rd_idx,
    input  logic [PW-1:0]       ptr_q,
    input  logic [DEPTH*AW-1:0] src_flat,
    input  logic [DEPTH*AW-1:0] dst_flat,
    input  logic [AW-1:0]       lex_from_q,
    input  logic [AW-1:0]       lex_to_q,
    input  logic                ctl_en,
    input  logic                ctl_frz_en,
    input  logic                frozen,
    output logic [AW-1:0]       rd_data
);

    logic [PW-1:0] sel;
    logic          hit_src, hit_dst;

    always_comb begin
        sel     = rd_idx[PW-1:0];
        hit_src = (rd_idx[IW-1:PW] == SRC_BASE[IW-1:PW]);
        hit_dst = (rd_idx[IW-1:PW] == DST_BASE[IW-1:PW]);
        rd_data = '0;
        if (hit_src)                rd_data = src_flat[AW*int'(sel) +: AW];
        else if (hit_dst)           rd_data = dst_flat[AW*int'(sel) +: AW];
        else if (rd_idx == PTR_IDX) rd_data = AW'(ptr_q);
        else if (rd_idx == LEXF_IDX) rd_data = lex_from_q;
        else if (rd_idx == LEXT_IDX) rd_data = lex_to_q;
        else if (rd_idx == CTRL_IDX) begin
            rd_data[CB_EN]     = ctl_en;
            rd_data[CB_FRZ_EN] = ctl_frz_en;
            rd_data[CB_FROZEN] = frozen;
        end
    end

    always_comb begin
        if (!hit_src && !hit_dst && rd_idx != PTR_IDX && rd_idx != LEXF_IDX
            && rd_idx != LEXT_IDX && rd_idx != CTRL_IDX)
            AST_UNMAPPED_ZERO: assert (rd_data == '0); // R11
    end

endmodule

// File: rtl/xfer_history_ring.sv
module xfer_history_ring
    import xfer_hist_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned AW    = 32,
    parameter int unsigned IW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_valid,
    input  logic [1:0]    cap_kind,
    input  logic [AW-1:0] cap_from,
    input  logic [AW-1:0] cap_to,
    input  logic          pmi_req,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [2:0]    wr_bits,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_data
);

    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IW-1:0] CTRL_IDX = IW'(12'h1D9);

    logic                rec_en, ctl_en, ctl_frz_en, frozen;
    logic [PW-1:0]       ptr_q;
    logic [DEPTH*AW-1:0] src_flat, dst_flat;
    logic [AW-1:0]       lex_from_q, lex_to_q;

    xfer_ctrl_fsm #(.IW(IW), .CTRL_IDX(CTRL_IDX)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .pmi_req(pmi_req),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_bits(wr_bits),
        .rec_en(rec_en), .ctl_en(ctl_en), .ctl_frz_en(ctl_frz_en), .frozen(frozen)
    );

    xfer_ring_store #(.DEPTH(DEPTH), .AW(AW)) u_ring (
        .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .cap_from(cap_from), .cap_to(cap_to),
        .ptr_q(ptr_q), .src_flat(src_flat), .dst_flat(dst_flat)
    );

    xfer_exc_latch #(.AW(AW)) u_lex (
        .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .cap_kind(cap_kind),
        .cap_from(cap_from), .cap_to(cap_to), .lex_from_q(lex_from_q), .lex_to_q(lex_to_q)
    );

    xfer_read_mux #(.DEPTH(DEPTH), .AW(AW), .IW(IW), .CTRL_IDX(CTRL_IDX)) u_rd (
        .rd_idx(rd_idx), .ptr_q(ptr_q), .src_flat(src_flat), .dst_flat(dst_flat),
        .lex_from_q(lex_from_q), .lex_to_q(lex_to_q), .ctl_en(ctl_en),
        .ctl_frz_en(ctl_frz_en), .frozen(frozen), .rd_data(rd_data)
    );

endmodule

// File: tb/sim_xfer_history_ring.sv
`timescale 1ns/1ps
module sim_xfer_history_ring;

    localparam int DEPTH = 4;
    localparam int AW    = 32;
    localparam int IW    = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap_valid = 1'b0;
    logic [1:0]    cap_kind = 2'd0;
    logic [AW-1:0] cap_from = '0;
    logic [AW-1:0] cap_to = '0;
    logic          pmi_req = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [2:0]    wr_bits = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [AW-1:0] rd_data;

    int n_vec = 0;
    int n_bad = 0;

    logic [AW-1:0] m_src [DEPTH];
    logic [AW-1:0] m_dst [DEPTH];
    logic [AW-1:0] m_lf, m_lt;
    int            m_ptr;
    bit            m_en, m_fen, m_frz;

    always #5 clk = ~clk;

    xfer_history_ring #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_kind(cap_kind),
        .cap_from(cap_from), .cap_to(cap_to), .pmi_req(pmi_req), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_bits(wr_bits), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    function automatic logic [AW-1:0] expv(int idx);
        logic [AW-1:0] v = '0;
        if (idx >= 'h40 && idx < 'h40 + DEPTH)      v = m_src[idx - 'h40];
        else if (idx >= 'h60 && idx < 'h60 + DEPTH) v = m_dst[idx - 'h60];
        else if (idx == 'h1C9) v = AW'(m_ptr);
        else if (idx == 'h1DD) v = m_lf;
        else if (idx == 'h1DE) v = m_lt;
        else if (idx == 'h1D9) v = AW'({m_frz, 1'b0, m_fen, m_en});
        return v;
    endfunction

    // full sweep of the read index space; tag names the requirement under test
    task automatic sweep(string tag);
        @(negedge clk);
        for (int i = 0; i < 'h200; i++) begin
            rd_idx = IW'(i);
            #1;
            n_vec++;
            if (rd_data !== expv(i)) begin
                n_bad++;
                $display("FAIL %s idx=%03h actual=%08h expected=%08h", tag, i, rd_data, expv(i));
            end
        end
    endtask

    function automatic void model_event(int kind, logic [AW-1:0] f, logic [AW-1:0] t);
        if (m_en && !m_frz) begin
            m_ptr = (m_ptr + 1) % DEPTH;
            m_src[m_ptr] = f;
            m_dst[m_ptr] = t;
            if (kind == 1 || kind == 2) begin
                m_lf = f;
                m_lt = t;
            end
        end
    endfunction

    task automatic event_cycle(int kind, logic [AW-1:0] f, logic [AW-1:0] t, bit with_pmi);
        @(negedge clk);
        cap_valid = 1'b1; cap_kind = 2'(kind); cap_from = f; cap_to = t;
        pmi_req = with_pmi;
        @(negedge clk);
        cap_valid = 1'b0; pmi_req = 1'b0;
        model_event(kind, f, t);
        if (with_pmi && m_en && !m_frz && m_fen) m_frz = 1'b1;
    endtask

    task automatic pmi_only();
        @(negedge clk);
        pmi_req = 1'b1;
        @(negedge clk);
        pmi_req = 1'b0;
        if (m_en && !m_frz && m_fen) m_frz = 1'b1;
    endtask

    task automatic ctl_write(logic [2:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(12'h1D9); wr_bits = b;
        @(negedge clk);
        wr_en = 1'b0;
        m_en = b[0]; m_fen = b[1];
        if (b[2]) m_frz = 1'b0;
    endtask

    function automatic logic [AW-1:0] gen_from(int i);
        return 32'hA000_0000 ^ (32'h0101_0101 * (i + 1));
    endfunction

    function automatic logic [AW-1:0] gen_to(int i);
        return gen_from(i) + 32'h40 + AW'(i * 3);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < DEPTH; i++) begin m_src[i] = '0; m_dst[i] = '0; end
        m_lf = '0; m_lt = '0; m_ptr = 0; m_en = 0; m_fen = 0; m_frz = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sweep("R1");                               // R1 reset state, R11 unmapped zero

        event_cycle(1, 32'h1111_1111, 32'h2222_2222, 1'b0);
        sweep("R6");                               // R6 idle ignores events

        ctl_write(3'b001);
        sweep("R7");                               // R7 control readback
        for (int i = 0; i < 10; i++) begin         // R2 R3 R4 R5 wrap and kinds
            event_cycle(i % 4, gen_from(i), gen_to(i), 1'b0);
            sweep("R2_R3_R4_R5");
        end

        pmi_only();                                // R7 no freeze without enable
        event_cycle(0, gen_from(20), gen_to(20), 1'b0);
        sweep("R7");

        ctl_write(3'b000);
        event_cycle(2, gen_from(21), gen_to(21), 1'b0);
        event_cycle(0, gen_from(22), gen_to(22), 1'b0);
        sweep("R6");

        ctl_write(3'b011);
        event_cycle(0, gen_from(23), gen_to(23), 1'b0);
        event_cycle(2, gen_from(24), gen_to(24), 1'b1);   // R10 same-cycle event
        sweep("R10");
        event_cycle(1, gen_from(25), gen_to(25), 1'b0);   // R8 frozen ignores
        event_cycle(0, gen_from(26), gen_to(26), 1'b0);
        sweep("R8");

        ctl_write(3'b111);                          // R9 release to RECORD
        event_cycle(1, gen_from(27), gen_to(27), 1'b0);
        sweep("R9");

        pmi_only();
        sweep("R8");
        ctl_write(3'b110);                          // R9 release to IDLE
        event_cycle(2, gen_from(28), gen_to(28), 1'b0);
        sweep("R9");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule